// File: doc/BRIEF.md
# Read-Modify-Write Memory Cycle Sequencer

This block runs one memory cycle on a word store whose read is destructive. The read phase senses the word and leaves it cleared, and the write phase then stores a value into the cleared word. Between the two phases a modify stage can change the sensed value. The requester chooses one of four operations: plain read, plain write, increment or decrement. So an increment or decrement finishes in one memory cycle. Without the modify stage it would take a read cycle and then a separate write cycle.

Requests enter on a valid/ready channel. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Results leave on a second valid/ready channel. After `rsp_valid` rises, the old value, the new value and the flag stay fixed until `rsp_ready` is seen high at a clock edge. No new request is taken before that edge, so the requester controls the pace on both sides.

The `pause` pin is a plain control input. The processor side uses it to stretch the modify stage. The sequencer stays in the modify stage on every edge where `pause` is high, and it moves to the write phase on the first edge where `pause` is low.

Top module: `rmw_cycle_seq`

## Requirements
- R1: Out of reset, `req_ready` is 1 and `rsp_valid` is 0. `req_ready` is never high while `rsp_valid` is high.
- R2: A plain read (`req_op` = 0) returns the stored word on both `rsp_old` and `rsp_new`, with `rsp_flag` 0. It writes the word back unchanged, so a later read returns the same value.
- R3: A plain write (`req_op` = 1) returns the previous word on `rsp_old` and stores `req_data`. `rsp_new` equals `req_data` and `rsp_flag` is 0.
- R4: An increment (`req_op` = 2) stores the old value plus one, modulo 2^WIDTH. `rsp_flag` is 1 exactly when the old value was all ones.
- R5: A decrement (`req_op` = 3) stores the old value minus one, modulo 2^WIDTH. `rsp_flag` is 1 exactly when the old value was zero.
- R6: The sequencer holds the modify stage on every edge where `pause` is high. The write phase begins on the first edge where `pause` is low. The delay from accept to `rsp_valid` is 3 edges plus one edge for each paused modify cycle.
- R7: `rsp_old` shows the sensed word from the end of the read phase on, which is one edge after accept. It keeps that value through the response.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_old`, `rsp_new` and `rsp_flag` do not change and `req_ready` stays 0.
- R9: With no pause, an increment reaches `rsp_valid` 3 edges after accept. This is strictly fewer edges than a read followed by a separate write, counted from the first accept to the second response.
- R10: Every read phase is followed by the modify stage and then a write phase to the same word. A word is always zero when its write phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears the store |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The sequencer is idle and can take a request |
| req_op | input | 2 | 0 read, 1 write, 2 increment, 3 decrement |
| req_addr | input | $clog2(DEPTH) | Word address |
| req_data | input | WIDTH | Data to store for a plain write |
| pause | input | 1 | Stretches the modify stage |
| rsp_valid | output | 1 | A result is offered |
| rsp_ready | input | 1 | The requester takes the result |
| rsp_old | output | WIDTH | Word sensed in the read phase |
| rsp_new | output | WIDTH | Word stored in the write phase |
| rsp_flag | output | 1 | Carry out of an increment, or borrow out of a decrement |

## Verification
The bench uses a 4-bit word and sweeps all sixteen values. Each value is written, read back, incremented and then decremented. This separates the two wrap points, all-ones for carry and zero for borrow, from the ordinary values, and it shows whether the write-back of a plain read keeps the word. Pause lengths from zero to three show whether the write phase starts exactly on the edge after `pause` drops. Holding `rsp_ready` low shows whether the response stays frozen. Comparing the increment delay with the delay of a read and write pair shows the cost of the single-cycle modify.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_INC   = 2'd2,
    OP_DEC   = 2'd3
  } rmw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE,
    ST_RESP
  } rmw_state_e;
endpackage

// File: rtl/rmw_modify_unit.sv
module rmw_modify_unit
  import rmw_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  rmw_op_e            op,
  input  logic [WIDTH-1:0]   sensed,
  input  logic [WIDTH-1:0]   supplied,
  output logic [WIDTH-1:0]   result,
  output logic               flag
);
  localparam int EXT = WIDTH + 1;

  logic [EXT-1:0] sum_ext;
  logic [EXT-1:0] dif_ext;

  // Extend by one bit so the carry or borrow lands in the top bit.
  assign sum_ext = {1'b0, sensed} + EXT'(1);
  assign dif_ext = {1'b0, sensed} - EXT'(1);

  always_comb begin
    result = sensed;
    flag   = 1'b0;
    unique case (op)
      OP_READ:  result = sensed;
      OP_WRITE: result = supplied;
      OP_INC: begin
        result = sum_ext[WIDTH-1:0];
        flag   = sum_ext[WIDTH];
      end
      OP_DEC: begin
        result = dif_ext[WIDTH-1:0];
        flag   = dif_ext[WIDTH];
      end
      default: result = sensed;
    endcase
  end
endmodule

// File: rtl/rmw_word_plane.sv
module rmw_word_plane #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // A sense empties the word; a write fills a word known to be empty.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (rd_en) begin
        rdata     <= mem[addr];
        mem[addr] <= '0;
      end else if (wr_en) begin
        mem[addr] <= wdata;
      end
    end
  end

  assert_write_after_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (mem[addr] == '0))
    else $error("write phase found a word that was not cleared");

  assert_no_read_write_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en))
    else $error("read and write phase in the same cycle");
endmodule

// File: rtl/rmw_phase_ctrl.sv
module rmw_phase_ctrl
  import rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       pause,
  input  logic       rsp_ready,
  output logic       req_ready,
  output logic       accept,
  output logic       rd_en,
  output logic       mod_done,
  output logic       wr_en,
  output logic       rsp_valid
);
  rmw_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (req_valid) state_nx = ST_READ;
      ST_READ:   state_nx = ST_MODIFY;
      ST_MODIFY: if (!pause) state_nx = ST_WRITE;
      ST_WRITE:  state_nx = ST_RESP;
      ST_RESP:   if (rsp_ready) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_en     = (state == ST_READ);
  assign mod_done  = (state == ST_MODIFY) && !pause;
  assign wr_en     = (state == ST_WRITE);
  assign rsp_valid = (state == ST_RESP);

  assert_read_then_modify_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (state == ST_MODIFY))
    else $error("read phase not followed by modify stage");

  assert_pause_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MODIFY && pause) |=> (state == ST_MODIFY))
    else $error("modify stage left while paused");

  assert_write_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MODIFY && !pause) |=> wr_en)
    else $error("write phase did not follow pause release");
endmodule

// File: rtl/rmw_cycle_seq.sv
module rmw_cycle_seq
  import rmw_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [WIDTH-1:0] req_data,
  input  logic             pause,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [WIDTH-1:0] rsp_old,
  output logic [WIDTH-1:0] rsp_new,
  output logic             rsp_flag
);
  logic             accept, rd_en, wr_en, mod_done;
  rmw_op_e          op_q;
  logic [AW-1:0]    addr_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] sensed;
  logic [WIDTH-1:0] mod_res;
  logic             mod_flag;
  logic [WIDTH-1:0] new_q;
  logic             flag_q;

  rmw_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .pause     (pause),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_en     (rd_en),
    .mod_done  (mod_done),
    .wr_en     (wr_en),
    .rsp_valid (rsp_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_READ;
      addr_q <= '0;
      data_q <= '0;
      new_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (accept) begin
        op_q   <= rmw_op_e'(req_op);
        addr_q <= req_addr;
        data_q <= req_data;
      end
      if (mod_done) begin
        new_q  <= mod_res;
        flag_q <= mod_flag;
      end
    end
  end

  rmw_word_plane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_plane (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr_q),
    .wdata (new_q),
    .rdata (sensed)
  );

  rmw_modify_unit #(.WIDTH(WIDTH)) u_modify (
    .op       (op_q),
    .sensed   (sensed),
    .supplied (data_q),
    .result   (mod_res),
    .flag     (mod_flag)
  );

  assign rsp_old  = sensed;
  assign rsp_new  = new_q;
  assign rsp_flag = flag_q;

  assert_ready_excludes_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid)
    else $error("ready while a response is pending");

  assert_rsp_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_old) && $stable(rsp_new)
                                   && $stable(rsp_flag)))
    else $error("response changed under back-pressure");
endmodule

// File: tb/rmw_cycle_seq_bench.sv
module rmw_cycle_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int D  = 4;
  localparam int AW = 2;
  localparam int VMAX = 1 << W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [W-1:0]  req_data = '0;
  logic          pause = 1'b0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [W-1:0]  rsp_old, rsp_new;
  logic          rsp_flag;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] ref_mem [D];

  always #(CLK_PERIOD/2) clk = ~clk;

  rmw_cycle_seq #(.WIDTH(W), .DEPTH(D)) u_rmw_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .pause(pause),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_old(rsp_old),
    .rsp_new(rsp_new), .rsp_flag(rsp_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One full request/response exchange; all driving on falling edges.
  task automatic run(input int op, input int a, input int d, input int npause,
                     input int hold, output int old_v, output int new_v,
                     output int flag_v, output int early_old, output int lat);
    int c;
    @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0]; req_addr = a[AW-1:0]; req_data = d[W-1:0];
    pause = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    c = 1;
    early_old = -1;
    while (!rsp_valid && c < 50) begin
      @(negedge clk);
      c++;
      if (c == 2) early_old = int'(rsp_old);
      pause = ((c - 2) < npause);
      if (c == 2 && npause == 0) pause = 1'b0;
    end
    pause = 1'b0;
    lat = c - 1;
    old_v = int'(rsp_old); new_v = int'(rsp_new); flag_v = int'(rsp_flag);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(rsp_valid && !req_ready && int'(rsp_old) == old_v &&
            int'(rsp_new) == new_v && int'(rsp_flag) == flag_v,
            "R8 held response", int'(rsp_new), new_v);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    int o, n, f, e, l, lr, lw, exp_v, dummy;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    for (int i = 0; i < D; i++) ref_mem[i] = '0;

    for (int v = 0; v < VMAX; v++) begin
      int a = v % D;
      run(1, a, v, 0, 0, o, n, f, e, l);
      check(o == int'(ref_mem[a]), "R3 write old", o, int'(ref_mem[a]));
      check(n == v && f == 0, "R3 write new", n, v);
      ref_mem[a] = v[W-1:0];
      run(0, a, 0, 0, 0, o, n, f, e, l);
      check(o == v && n == v && f == 0, "R2 read", o, v);
      run(2, a, 0, 0, 0, o, n, f, e, l);
      exp_v = (v + 1) % VMAX;
      check(n == exp_v, "R4 inc value", n, exp_v);
      check(f == (v == VMAX - 1 ? 1 : 0), "R4 carry", f, (v == VMAX - 1) ? 1 : 0);
      check(e == v, "R7 early old", e, v);
      check(l == 3, "R9 inc latency", l, 3);
      run(3, a, 0, 0, 0, o, n, f, e, l);
      check(o == exp_v && n == v, "R5 dec value", n, v);
      check(f == (exp_v == 0 ? 1 : 0), "R5 borrow", f, (exp_v == 0) ? 1 : 0);
      ref_mem[a] = v[W-1:0];
    end

    for (int p = 0; p < 4; p++) begin
      run(2, 1, 0, p, 0, o, n, f, e, l);
      exp_v = (int'(ref_mem[1]) + 1) % VMAX;
      check(l == 3 + p, "R6 pause latency", l, 3 + p);
      check(n == exp_v, "R6 paused inc value", n, exp_v);
      ref_mem[1] = exp_v[W-1:0];
    end

    run(3, 2, 0, 1, 3, o, n, f, e, l);
    exp_v = (int'(ref_mem[2]) + VMAX - 1) % VMAX;
    check(n == exp_v, "R8 value after hold", n, exp_v);
    ref_mem[2] = exp_v[W-1:0];

    run(0, 3, 0, 0, 0, o, n, f, e, lr);
    run(1, 3, o + 1, 0, 0, dummy, n, f, e, lw);
    ref_mem[3] = n[W-1:0];
    run(2, 0, 0, 0, 0, o, n, f, e, l);
    ref_mem[0] = n[W-1:0];
    check(l < lr + lw + 2, "R9 single cycle beats pair", l, lr + lw + 2);

    for (int i = 0; i < D; i++) begin
      run(0, i, 0, 0, 0, o, n, f, e, l);
      check(o == int'(ref_mem[i]) && n == o, "R2 final contents", o, int'(ref_mem[i]));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule